// File: doc/BRIEF.md
# MAC Accumulator and Status Register File

This block is the storage side of a multiply-accumulate engine. It holds four 48-bit accumulators, a 32-bit address mask and a status word. The status word carries four mode bits and the condition flags. Software reaches every register through one addressed port: writes are synchronous and reads are combinational from the address.

The arithmetic sits outside the block. After it finishes a multiply-add or multiply-subtract, it presents the result on an update port: a destination index, the full 48-bit value and one bit that reports an overflow in the product or in the sum. The block stores the value. It raises a per-accumulator overflow flag that stays set until it is cleared, and it refreshes the negative, zero and overflow flags. It also drives the mode bits and the mask to the arithmetic, which needs them on every cycle.

Top module: `accStatusFile`

## Requirements
- R1: After reset the status register (address 0x804) reads 0x0000_0000 and the mask register (address 0x805) reads 0xFFFF_FFFF.
- R2: The register map is 0x804 status, 0x805 mask, 0x806/0x809/0x80A/0x80B the low 32 bits of accumulators 0/1/2/3, 0x807 the upper bits of accumulators 0 and 1, 0x808 the upper bits of accumulators 2 and 3. Any other address reads zero, and a write to it changes no register.
- R3: Status bits 31..12 always read zero, whatever was written. Bits 11..8 are the overflow flags, with bit 8+n belonging to accumulator n. Bits 7..0 are, from bit 7 down: saturation mode, signed/unsigned, fraction/integer, round/truncate, N, Z, V, EV.
- R4: A status write loads bits 7..0 as written. If the written bit 1 (V) is 1, bits 11..8 take the written overflow flags. If it is 0, all four overflow flags clear.
- R5: Each accumulator is 48 bits. A write to its low address replaces bits 31..0 and leaves bits 47..32. Bits 15..0 of an extension register hold bits 47..32 of the even accumulator of the pair, and bits 31..16 hold those of the odd one. An extension write replaces the upper bits of both accumulators of the pair and leaves their low bits.
- R6: An update that is not blocked (R10) stores all 48 bits of the value into the accumulator named by the index.
- R7: After a stored update, N equals bit 47 of the value, and Z is 1 exactly when all 48 bits are zero.
- R8: An update with the overflow bit set raises that accumulator's overflow flag, and the flag then stays set across later updates. After each update V equals the destination's overflow flag, including any overflow this update raises.
- R9: A write to an accumulator's low address, or to the extension register that holds its upper bits, clears that accumulator's overflow flag. V is left unchanged.
- R10: If a register write targets the update's destination accumulator (its low address or its extension register) in the same cycle, the register write is performed. The update is dropped completely, and that accumulator's overflow flag clears.
- R11: If a status write and an update meet in the same cycle, the status register takes the written value. The update's value is still stored in its accumulator.
- R12: The mask register is read/write, and its value drives the addrMask output. The macMode output always equals status bits 7..4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register address, used for both read and write |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| updValid | input | 1 | Result update strobe from the arithmetic |
| updIdx | input | 2 | Destination accumulator of the update |
| updValue | input | 48 | Result value |
| updOvf | input | 1 | Overflow raised while computing the result |
| macMode | output | 4 | Saturation, signed, fraction and round mode bits |
| addrMask | output | 32 | Current mask register value |

## Verification
The assertions assume that regAddr, regWrEn, updValid, updIdx and updValue are stable and free of unknowns around each rising clock edge. They also assume that the index of an update always names one of the four accumulators. The bench drives every input at the falling edge and holds it for a full cycle. It uses only the 2-bit index range, and it sets the update and register strobes together only in the same-cycle cases that R10 and R11 describe.

// File: rtl/accStatusPkg.sv
package accStatusPkg;

  localparam int ADDR_W   = 12;
  localparam int ACC_CNT  = 4;
  localparam int PAIR_CNT = ACC_CNT / 2;
  localparam int IDX_W    = $clog2(ACC_CNT);
  localparam int STAT_USED = 12;

  localparam logic [ADDR_W-1:0] STATUS_ADDR = 12'h804;
  localparam logic [ADDR_W-1:0] MASK_ADDR   = 12'h805;
  localparam logic [ADDR_W-1:0] EXT_BASE    = 12'h807;

  // Low-word address of each accumulator; the map is not contiguous.
  function automatic logic [ADDR_W-1:0] accLoAddr(input int n);
    case (n)
      0:       accLoAddr = 12'h806;
      1:       accLoAddr = 12'h809;
      2:       accLoAddr = 12'h80A;
      default: accLoAddr = 12'h80B;
    endcase
  endfunction

  typedef struct packed {
    logic                wrStatus;
    logic                wrMask;
    logic [ACC_CNT-1:0]  wrAccLo;
    logic [PAIR_CNT-1:0] wrExt;
    logic [ACC_CNT-1:0]  accClr;
    logic                updStore;
    logic                updFlags;
    logic [IDX_W-1:0]    updIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/accStatusCtrl.sv
module accStatusCtrl
  import accStatusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updIdx,
  output ctrlStrobes_t      strobes
);

  logic collide;

  always_comb begin
    strobes = '0;
    strobes.wrStatus = regWrEn && (regAddr == STATUS_ADDR);
    strobes.wrMask   = regWrEn && (regAddr == MASK_ADDR);
    for (int n = 0; n < ACC_CNT; n++) begin
      strobes.wrAccLo[n] = regWrEn && (regAddr == accLoAddr(n));
    end
    for (int p = 0; p < PAIR_CNT; p++) begin
      strobes.wrExt[p] = regWrEn && (regAddr == EXT_BASE + ADDR_W'(p));
    end
    for (int n = 0; n < ACC_CNT; n++) begin
      strobes.accClr[n] = strobes.wrAccLo[n] | strobes.wrExt[n/2];
    end
    collide          = updValid && strobes.accClr[updIdx];
    strobes.updStore = updValid && !collide;
    strobes.updFlags = strobes.updStore && !strobes.wrStatus;
    strobes.updIdx   = updIdx;
  end

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrStatus, strobes.wrMask, strobes.wrAccLo, strobes.wrExt}));

  // R10
  upd_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && regWrEn && (regAddr == accLoAddr(int'(updIdx)))) |-> !strobes.updStore);

endmodule

// File: rtl/accStatusDatapath.sv
module accStatusDatapath
  import accStatusPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ACC_W-1:0]  updValue,
  input  logic              updOvf,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        macMode,
  output logic [DATA_W-1:0] addrMask
);

  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0]   accVec  [ACC_CNT];
  logic [DATA_W-1:0]  extWord [PAIR_CNT];
  logic [ACC_CNT-1:0] pav, pavSet;
  logic [3:0]         modeR;
  logic               nF, zF, vF, evF;
  logic [DATA_W-1:0]  maskR;
  logic [DATA_W-1:0]  statusWord;

  // Accumulator storage, one slot per accumulator.
  for (genvar n = 0; n < ACC_CNT; n++) begin : g_acc
    localparam int PAIR = n / 2;
    logic [ACC_W-1:0] accQ;
    logic [EXT_W-1:0] extLane;

    if ((n % 2) == 1) begin : g_hiLane
      assign extLane = wrData[DATA_W-1 -: EXT_W];
    end else begin : g_loLane
      assign extLane = wrData[EXT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accQ <= '0;
      end else if (strobes.wrAccLo[n]) begin
        accQ[DATA_W-1:0] <= wrData;
      end else if (strobes.wrExt[PAIR]) begin
        accQ[ACC_W-1:DATA_W] <= extLane;
      end else if (strobes.updStore && (strobes.updIdx == IDX_W'(n))) begin
        accQ <= updValue;
      end
    end

    assign accVec[n] = accQ;
  end

  // Overflow flag raised by the current update.
  always_comb begin
    pavSet = '0;
    if (strobes.updFlags && updOvf) pavSet[strobes.updIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pav   <= '0;
      modeR <= '0;
      nF    <= 1'b0;
      zF    <= 1'b0;
      vF    <= 1'b0;
      evF   <= 1'b0;
    end else if (strobes.wrStatus) begin
      modeR <= wrData[7:4];
      nF    <= wrData[3];
      zF    <= wrData[2];
      vF    <= wrData[1];
      evF   <= wrData[0];
      pav   <= wrData[1] ? wrData[11:8] : '0;
    end else begin
      pav <= (pav | pavSet) & ~strobes.accClr;
      if (strobes.updFlags) begin
        nF <= updValue[ACC_W-1];
        zF <= (updValue == '0);
        vF <= pav[strobes.updIdx] | updOvf;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               maskR <= '1;
    else if (strobes.wrMask) maskR <= wrData;
  end

  always_comb begin
    statusWord = '0;
    statusWord[STAT_USED-1:0] = {pav, modeR, nF, zF, vF, evF};
  end

  always_comb begin
    for (int p = 0; p < PAIR_CNT; p++) begin
      extWord[p] = '0;
      extWord[p][EXT_W-1:0]           = accVec[2*p][ACC_W-1:DATA_W];
      extWord[p][DATA_W-1 -: EXT_W]   = accVec[2*p+1][ACC_W-1:DATA_W];
    end
  end

  always_comb begin
    rdData = '0;
    if (regAddr == STATUS_ADDR) rdData = statusWord;
    if (regAddr == MASK_ADDR)   rdData = maskR;
    for (int n = 0; n < ACC_CNT; n++) begin
      if (regAddr == accLoAddr(n)) rdData = accVec[n][DATA_W-1:0];
    end
    for (int p = 0; p < PAIR_CNT; p++) begin
      if (regAddr == EXT_BASE + ADDR_W'(p)) rdData = extWord[p];
    end
  end

  assign macMode  = modeR;
  assign addrMask = maskR;

  // R8
  pav_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wrStatus && (strobes.accClr == '0)) |=> ((pav & $past(pav)) == $past(pav)));

  // R8
  vflag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updFlags |=> (vF == pav[$past(strobes.updIdx)]));

  // R9
  pav_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accClr != '0) |=> ((pav & $past(strobes.accClr)) == '0));

  // R7
  nz_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updFlags |=> ((nF == $past(updValue[ACC_W-1])) && (zF == ($past(updValue) == '0))));

  // R11
  status_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStatus |=> ((vF == $past(wrData[1])) && (macMode == $past(wrData[7:4]))));

endmodule

// File: rtl/accStatusFile.sv
module accStatusFile
  import accStatusPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updIdx,
  input  logic [ACC_W-1:0]  updValue,
  input  logic              updOvf,
  output logic [3:0]        macMode,
  output logic [DATA_W-1:0] addrMask
);

  ctrlStrobes_t strobes;

  accStatusCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .updValid (updValid),
    .updIdx   (updIdx),
    .strobes  (strobes)
  );

  accStatusDatapath #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regAddr  (regAddr),
    .wrData   (regWrData),
    .updValue (updValue),
    .updOvf   (updOvf),
    .rdData   (regRdData),
    .macMode  (macMode),
    .addrMask (addrMask)
  );

endmodule

// File: tb/accStatusFile_tb.sv
module accStatusFile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        updValid = 1'b0;
  logic [1:0]  updIdx = '0;
  logic [47:0] updValue = '0;
  logic        updOvf = 1'b0;
  logic [3:0]  macMode;
  logic [31:0] addrMask;

  accStatusFile u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .updValid(updValid),
    .updIdx(updIdx), .updValue(updValue), .updOvf(updOvf),
    .macMode(macMode), .addrMask(addrMask)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] exp;
    int          sel;   // 0 read data, 1 macMode, 2 addrMask
    logic [11:0] addr;
    string       tag;
  } item_t;

  item_t expQ[$];
  event  sampleEv;
  int    checkCnt = 0;
  int    failCnt = 0;
  bit    finished = 0;

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.sel)
          1:       act = {28'h0, macMode};
          2:       act = addrMask;
          default: act = regRdData;
        endcase
        checkCnt++;
        if (act !== it.exp) begin
          failCnt++;
          $display("FAIL %s addr=%h sel=%0d actual=%h expected=%h",
                   it.tag, it.addr, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expectOut(input logic [11:0] addr, input int sel,
                           input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    regAddr = addr;
    #2;
    it.exp = exp; it.sel = sel; it.addr = addr; it.tag = tag;
    expQ.push_back(it);
    -> sampleEv;
    #1;
  endtask

  task automatic regWrite(input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic update(input logic [1:0] idx, input logic [47:0] val, input logic ovf);
    @(negedge clk);
    updIdx = idx; updValue = val; updOvf = ovf; updValid = 1'b1;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic both(input logic [11:0] addr, input logic [31:0] data,
                      input logic [1:0] idx, input logic [47:0] val, input logic ovf);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    updIdx = idx; updValue = val; updOvf = ovf; updValid = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; updValid = 1'b0;
  endtask

  task automatic finish();
    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R12 reset state
    expectOut(12'h804, 0, 32'h0000_0000, "R1 status reset");
    expectOut(12'h805, 0, 32'hFFFF_FFFF, "R1 mask reset");
    expectOut(12'h804, 1, 32'h0,         "R12 macMode reset");
    expectOut(12'h804, 2, 32'hFFFF_FFFF, "R12 addrMask reset");

    // R5 split accumulator storage
    regWrite(12'h806, 32'h1234_5678);
    regWrite(12'h807, 32'hAAAA_5555);
    expectOut(12'h806, 0, 32'h1234_5678, "R5 ext write keeps low word");
    expectOut(12'h807, 0, 32'hAAAA_5555, "R5 ext lanes");
    regWrite(12'h806, 32'h0BAD_F00D);
    expectOut(12'h807, 0, 32'hAAAA_5555, "R5 low write keeps upper bits");
    expectOut(12'h806, 0, 32'h0BAD_F00D, "R5 low word");

    // R2 unmapped addresses
    expectOut(12'h803, 0, 32'h0, "R2 unmapped read");
    regWrite(12'h80C, 32'hDEAD_BEEF);
    expectOut(12'h80C, 0, 32'h0,         "R2 unmapped write");
    expectOut(12'h804, 0, 32'h0,         "R2 status untouched");
    expectOut(12'h805, 0, 32'hFFFF_FFFF, "R2 mask untouched");

    // R3 / R4 status write
    regWrite(12'h804, 32'hFFFF_FFFF);
    expectOut(12'h804, 0, 32'h0000_0FFF, "R3 reserved bits read zero");
    expectOut(12'h804, 1, 32'hF,         "R12 macMode follows status");
    regWrite(12'h804, 32'h0000_0AF0);
    expectOut(12'h804, 0, 32'h0000_00F0, "R4 V=0 clears overflow flags");

    // R12 mask
    regWrite(12'h805, 32'h0000_ABCD);
    expectOut(12'h805, 0, 32'h0000_ABCD, "R12 mask readback");
    expectOut(12'h804, 2, 32'h0000_ABCD, "R12 addrMask output");

    // R6 / R7 / R8 updates
    regWrite(12'h808, 32'h1111_2222);
    update(2'd2, 48'h8000_0000_0001, 1'b0);
    expectOut(12'h80A, 0, 32'h0000_0001, "R6 acc2 low word");
    expectOut(12'h808, 0, 32'h1111_8000, "R6 acc2 upper bits");
    expectOut(12'h804, 0, 32'h0000_00F8, "R7 N set");
    update(2'd1, 48'h0, 1'b1);
    expectOut(12'h804, 0, 32'h0000_02F6, "R7 Z set, R8 flag raised");
    expectOut(12'h809, 0, 32'h0,         "R6 acc1 zero value");
    update(2'd1, 48'h1, 1'b0);
    expectOut(12'h804, 0, 32'h0000_02F2, "R8 sticky flag drives V");
    update(2'd0, 48'h5, 1'b0);
    expectOut(12'h804, 0, 32'h0000_02F0, "R8 V from destination flag");

    // R9 direct writes clear flags
    regWrite(12'h809, 32'h0000_0007);
    expectOut(12'h804, 0, 32'h0000_00F0, "R9 low write clears flag");
    update(2'd3, 48'h1, 1'b1);
    expectOut(12'h804, 0, 32'h0000_08F2, "R8 acc3 flag");
    regWrite(12'h808, 32'h0);
    expectOut(12'h804, 0, 32'h0000_00F2, "R9 ext write clears pair flags");
    regWrite(12'h804, 32'h0000_0F03);
    expectOut(12'h804, 0, 32'h0000_0F03, "R4 V=1 loads flags");
    regWrite(12'h804, 32'h0000_0F00);
    expectOut(12'h804, 0, 32'h0000_0000, "R4 V=0 clears flags");

    // R10 collisions
    update(2'd0, 48'h9, 1'b1);
    expectOut(12'h804, 0, 32'h0000_0102, "R8 acc0 flag");
    both(12'h806, 32'h0000_CAFE, 2'd0, 48'h0, 1'b1);
    expectOut(12'h804, 0, 32'h0000_0002, "R10 update dropped, flag cleared");
    expectOut(12'h806, 0, 32'h0000_CAFE, "R10 register write wins");
    expectOut(12'h807, 0, 32'h0000_0000, "R10 upper bits untouched");
    both(12'h807, 32'h0000_0012, 2'd1, 48'hFFFF_FFFF_FFFF, 1'b1);
    expectOut(12'h809, 0, 32'h0000_0007, "R10 ext collision drops update");
    expectOut(12'h804, 0, 32'h0000_0002, "R10 flags unchanged");

    // R11 status write with update
    both(12'h804, 32'h0000_0040, 2'd3, 48'h77, 1'b1);
    expectOut(12'h804, 0, 32'h0000_0040, "R11 status write wins");
    expectOut(12'h80B, 0, 32'h0000_0077, "R11 value still stored");
    expectOut(12'h804, 1, 32'h4,         "R11 macMode");

    repeat (2) @(negedge clk);
    finish();
  end

endmodule